// File: doc/BRIEF.md
# Shared-RAM Multi-FIFO Partition Manager

This block carves one single-port RAM of 32-bit words into one receive FIFO and `NUM_TX` transmit FIFOs. Every FIFO has its own programmable depth. The regions are packed with no gaps: the receive region comes first at word 0, and each transmit region begins at the word after the one before it ends. Each FIFO keeps its own read and write offsets, and these wrap inside its own region. Each FIFO reports its fill level, full and empty. Sizes are counted in words, so an L-byte packet needs ceil(L/4) words. A transmit FIFO is only useful if it can hold the largest packet of its endpoint. The receive FIFO also holds the completion status words that the packet side pushes after an endpoint's last packet.

Two requesters share the RAM. The packet side pushes received words into the receive FIFO and pops transmit words out of a chosen transmit FIFO. The bus side pushes words into a chosen transmit FIFO and pops words from the receive FIFO. The packet side has fixed priority. A bus request that loses arbitration has no effect, and the requester keeps it asserted until `busGnt` is seen. After the depths are changed, software must flush the FIFOs. Flush control can clear a single transmit FIFO, all transmit FIFOs through a reserved selector value, or the receive FIFO.

Top module: `shared_fifo_mgr`

## Requirements
- R1: The receive region occupies words 0 to rxDepth-1. Transmit FIFO k starts at rxDepth plus the sum of the depths of transmit FIFOs 0 to k-1. When every FIFO is filled at once, each FIFO returns exactly the words written to it.
- R2: Each FIFO returns its words in push order. Its offsets wrap from the last word of its region back to its first word.
- R3: `fifoLevel` slice i (index 0 = receive, index k+1 = transmit k) changes by one on the cycle after an accepted push or pop. `fifoFull[i]` is high when the level equals the depth, and `fifoEmpty[i]` is high when the level is zero.
- R4: A push to a full FIFO is ignored, and `ovfErr` is high on the next cycle. A pop from an empty FIFO is ignored, gives no valid, and `udfErr` is high on the next cycle.
- R5: `busGnt` equals `busReq & ~pktReq` in the same cycle. A bus request without a grant changes no FIFO.
- R6: On the cycle after an accepted pop, `rdData` holds the popped word. `pktRdValid` is high if the pop came from the packet side (`pktWr`=0, pop transmit FIFO `pktTxSel`). `busRdValid` is high if it came from the bus side (`busWr`=0, pop the receive FIFO).
- R7: `flushTxReq` with `flushTxSel` = k, where k < NUM_TX, empties transmit FIFO k on the next cycle and leaves the other FIFOs unchanged. A selector that is neither below NUM_TX nor 0x10 flushes nothing.
- R8: `flushTxReq` with `flushTxSel` = 0x10 empties every transmit FIFO on the next cycle and leaves the receive FIFO unchanged.
- R9: `flushRxReq` empties the receive FIFO on the next cycle. An access in the same cycle to a FIFO being flushed is dropped, and no error is raised.
- R10: `cfgErr` is high while the sum of all depths exceeds `RAM_WORDS`. While it is high, every push is dropped without `ovfErr`, and pops are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRxDepth | input | DEPTH_W | Receive FIFO depth in words |
| cfgTxDepth | input | NUM_TX*DEPTH_W | Transmit FIFO depths, FIFO 0 in the low slice |
| flushTxReq | input | 1 | Transmit flush strobe |
| flushTxSel | input | 5 | Transmit FIFO number to flush, 0x10 = all |
| flushRxReq | input | 1 | Receive flush strobe |
| pktReq | input | 1 | Packet-side access request |
| pktWr | input | 1 | 1 = push receive FIFO, 0 = pop transmit FIFO |
| pktTxSel | input | TXSEL_W | Transmit FIFO popped by the packet side |
| pktWrData | input | DATA_W | Word pushed by the packet side |
| busReq | input | 1 | Bus-side access request |
| busWr | input | 1 | 1 = push transmit FIFO, 0 = pop receive FIFO |
| busTxSel | input | TXSEL_W | Transmit FIFO pushed by the bus side |
| busWrData | input | DATA_W | Word pushed by the bus side |
| busGnt | output | 1 | Bus request accepted this cycle |
| rdData | output | DATA_W | Popped word |
| pktRdValid | output | 1 | rdData belongs to the packet side |
| busRdValid | output | 1 | rdData belongs to the bus side |
| fifoFull | output | NUM_TX+1 | Per-FIFO full, bit 0 = receive |
| fifoEmpty | output | NUM_TX+1 | Per-FIFO empty, bit 0 = receive |
| fifoLevel | output | (NUM_TX+1)*DEPTH_W | Per-FIFO fill level, receive in the low slice |
| ovfErr | output | 1 | Push to full FIFO was dropped last cycle |
| udfErr | output | 1 | Pop from empty FIFO was dropped last cycle |
| cfgErr | output | 1 | Regions exceed the RAM |

## Verification
The functions that meet in a single cycle are arbitration and flush. A packet-side access, a bus-side access and a flush strobe can all arrive on the same edge, possibly aimed at the same FIFO. Random traffic drives both sides at a high rate and flushes now and then. Directed steps add a push by both sides at once, and a receive push in the same cycle as a receive flush. A bench model applies priority first and flush precedence second, and then predicts the grant, the levels, the dropped accesses and the absence of error flags.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  localparam int FLUSH_SEL_W = 5;
  localparam logic [FLUSH_SEL_W-1:0] FLUSH_ALL = 5'h10;

  typedef struct packed {
    logic ramWe;
    logic ramRe;
    logic srcBus;
    logic pktRd;
    logic busRd;
  } ramStrobe_t;
endpackage

// File: rtl/mfifo_layout.sv
module mfifo_layout #(
  parameter int NF = 5,
  parameter int DEPTH_W = 9,
  parameter int SUM_W = 12,
  parameter int RAM_WORDS = 256
) (
  input  logic [NF*DEPTH_W-1:0] depthAll,
  output logic [NF*SUM_W-1:0]   startAll,
  output logic                  cfgErr
);
  logic [SUM_W-1:0] total;

  // Running sum: region i begins where region i-1 ends.
  always_comb begin
    logic [SUM_W-1:0] run;
    run = '0;
    for (int i = 0; i < NF; i++) begin
      startAll[i*SUM_W +: SUM_W] = run;
      run = run + SUM_W'(depthAll[i*DEPTH_W +: DEPTH_W]);
    end
    total = run;
  end

  assign cfgErr = total > SUM_W'(RAM_WORDS);
endmodule

// File: rtl/mfifo_ctrl.sv
module mfifo_ctrl
  import mfifo_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int RAM_WORDS = 256,
  localparam int NF = NUM_TX + 1,
  localparam int ADDR_W = $clog2(RAM_WORDS),
  localparam int DEPTH_W = ADDR_W + 1,
  localparam int IDX_W = $clog2(NF),
  localparam int SUM_W = DEPTH_W + IDX_W,
  localparam int TXSEL_W = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NF*DEPTH_W-1:0]  depthAll,
  input  logic [NF*SUM_W-1:0]    startAll,
  input  logic                   cfgErr,
  input  logic                   flushTxReq,
  input  logic [FLUSH_SEL_W-1:0] flushTxSel,
  input  logic                   flushRxReq,
  input  logic                   pktReq,
  input  logic                   pktWr,
  input  logic [TXSEL_W-1:0]     pktTxSel,
  input  logic                   busReq,
  input  logic                   busWr,
  input  logic [TXSEL_W-1:0]     busTxSel,
  output logic                   busGnt,
  output ramStrobe_t             strobe,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic [NF-1:0]          fifoFull,
  output logic [NF-1:0]          fifoEmpty,
  output logic [NF*DEPTH_W-1:0]  fifoLevel,
  output logic                   ovfErr,
  output logic                   udfErr
);
  logic [NF-1:0]      flushMask;
  logic [IDX_W-1:0]   tgt;
  logic               opValid, opWr, opBus, selOk, hit;
  logic               doWr, doRd, ovfNext, udfNext;
  logic [DEPTH_W-1:0] wrOffA [NF];
  logic [DEPTH_W-1:0] rdOffA [NF];
  logic [SUM_W-1:0]   startA [NF];
  logic [DEPTH_W-1:0] offSel;

  // Flush decode: receive has its own strobe, transmit uses a selector.
  always_comb begin
    flushMask = '0;
    flushMask[0] = flushRxReq;
    for (int k = 0; k < NUM_TX; k++) begin
      if (flushTxReq && (flushTxSel == FLUSH_ALL || flushTxSel == FLUSH_SEL_W'(k)))
        flushMask[k+1] = 1'b1;
    end
  end

  // Fixed priority: the packet side owns the RAM whenever it asks.
  assign busGnt = busReq & ~pktReq;

  always_comb begin
    opValid = pktReq | busReq;
    opBus   = ~pktReq;
    opWr    = pktReq ? pktWr : busWr;
    if (pktReq) begin
      tgt   = pktWr ? '0 : IDX_W'(pktTxSel) + IDX_W'(1);
      selOk = pktWr || (32'(pktTxSel) < NUM_TX);
    end else begin
      tgt   = busWr ? IDX_W'(busTxSel) + IDX_W'(1) : '0;
      selOk = !busWr || (32'(busTxSel) < NUM_TX);
    end
  end

  assign hit     = opValid && selOk && !flushMask[tgt];
  assign doWr    = hit && opWr && !fifoFull[tgt] && !cfgErr;
  assign doRd    = hit && !opWr && !fifoEmpty[tgt];
  assign ovfNext = hit && opWr && fifoFull[tgt] && !cfgErr;
  assign udfNext = hit && !opWr && fifoEmpty[tgt];

  assign offSel  = opWr ? wrOffA[tgt] : rdOffA[tgt];
  assign ramAddr = ADDR_W'(startA[tgt] + SUM_W'(offSel));

  always_comb begin
    strobe.ramWe  = doWr;
    strobe.ramRe  = doRd;
    strobe.srcBus = opBus;
    strobe.pktRd  = doRd && !opBus;
    strobe.busRd  = doRd && opBus;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fifo
    logic [DEPTH_W-1:0] cnt, wrOff, rdOff, dep;
    logic myWr, myRd;

    assign dep  = depthAll[i*DEPTH_W +: DEPTH_W];
    assign myWr = doWr && (tgt == IDX_W'(i));
    assign myRd = doRd && (tgt == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt   <= '0;
        wrOff <= '0;
        rdOff <= '0;
      end else if (flushMask[i]) begin
        cnt   <= '0;
        wrOff <= '0;
        rdOff <= '0;
      end else begin
        if (myWr) begin
          wrOff <= (wrOff == dep - 1'b1) ? '0 : wrOff + 1'b1;
          cnt   <= cnt + 1'b1;
        end
        if (myRd) begin
          rdOff <= (rdOff == dep - 1'b1) ? '0 : rdOff + 1'b1;
          cnt   <= cnt - 1'b1;
        end
      end
    end

    assign wrOffA[i] = wrOff;
    assign rdOffA[i] = rdOff;
    assign startA[i] = startAll[i*SUM_W +: SUM_W];
    assign fifoFull[i]  = (cnt == dep);
    assign fifoEmpty[i] = (cnt == '0);
    assign fifoLevel[i*DEPTH_W +: DEPTH_W] = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfErr <= 1'b0;
      udfErr <= 1'b0;
    end else begin
      ovfErr <= ovfNext;
      udfErr <= udfNext;
    end
  end
endmodule

// File: rtl/mfifo_dpath.sv
module mfifo_dpath
  import mfifo_pkg::*;
#(
  parameter int RAM_WORDS = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [DATA_W-1:0] pktWrData,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pktRdValid,
  output logic              busRdValid
);
  logic [DATA_W-1:0] mem [RAM_WORDS];

  // Single port: at most one of write or read per cycle.
  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[ramAddr] <= strobe.srcBus ? busWrData : pktWrData;
    if (strobe.ramRe) rdData <= mem[ramAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktRdValid <= 1'b0;
      busRdValid <= 1'b0;
    end else begin
      pktRdValid <= strobe.pktRd;
      busRdValid <= strobe.busRd;
    end
  end
endmodule

// File: rtl/shared_fifo_mgr.sv
module shared_fifo_mgr
  import mfifo_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int RAM_WORDS = 256,
  parameter int DATA_W = 32,
  localparam int NF = NUM_TX + 1,
  localparam int ADDR_W = $clog2(RAM_WORDS),
  localparam int DEPTH_W = ADDR_W + 1,
  localparam int IDX_W = $clog2(NF),
  localparam int SUM_W = DEPTH_W + IDX_W,
  localparam int TXSEL_W = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DEPTH_W-1:0]        cfgRxDepth,
  input  logic [NUM_TX*DEPTH_W-1:0] cfgTxDepth,
  input  logic                      flushTxReq,
  input  logic [4:0]                flushTxSel,
  input  logic                      flushRxReq,
  input  logic                      pktReq,
  input  logic                      pktWr,
  input  logic [TXSEL_W-1:0]        pktTxSel,
  input  logic [DATA_W-1:0]         pktWrData,
  input  logic                      busReq,
  input  logic                      busWr,
  input  logic [TXSEL_W-1:0]        busTxSel,
  input  logic [DATA_W-1:0]         busWrData,
  output logic                      busGnt,
  output logic [DATA_W-1:0]         rdData,
  output logic                      pktRdValid,
  output logic                      busRdValid,
  output logic [NF-1:0]             fifoFull,
  output logic [NF-1:0]             fifoEmpty,
  output logic [NF*DEPTH_W-1:0]     fifoLevel,
  output logic                      ovfErr,
  output logic                      udfErr,
  output logic                      cfgErr
);
  logic [NF*DEPTH_W-1:0] depthAll;
  logic [NF*SUM_W-1:0]   startAll;
  ramStrobe_t            strobe;
  logic [ADDR_W-1:0]     ramAddr;

  assign depthAll = {cfgTxDepth, cfgRxDepth};

  mfifo_layout #(.NF(NF), .DEPTH_W(DEPTH_W), .SUM_W(SUM_W), .RAM_WORDS(RAM_WORDS)) layout_i (
    .depthAll(depthAll), .startAll(startAll), .cfgErr(cfgErr)
  );

  mfifo_ctrl #(.NUM_TX(NUM_TX), .RAM_WORDS(RAM_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .depthAll(depthAll), .startAll(startAll), .cfgErr(cfgErr),
    .flushTxReq(flushTxReq), .flushTxSel(flushTxSel), .flushRxReq(flushRxReq),
    .pktReq(pktReq), .pktWr(pktWr), .pktTxSel(pktTxSel),
    .busReq(busReq), .busWr(busWr), .busTxSel(busTxSel),
    .busGnt(busGnt), .strobe(strobe), .ramAddr(ramAddr),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel),
    .ovfErr(ovfErr), .udfErr(udfErr)
  );

  mfifo_dpath #(.RAM_WORDS(RAM_WORDS), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramAddr(ramAddr),
    .pktWrData(pktWrData), .busWrData(busWrData),
    .rdData(rdData), .pktRdValid(pktRdValid), .busRdValid(busRdValid)
  );
endmodule

// File: rtl/mfifo_chk.sv
module mfifo_chk #(
  parameter int NUM_TX = 4,
  localparam int NF = NUM_TX + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          pktReq,
  input logic          pktWr,
  input logic          busReq,
  input logic          busGnt,
  input logic          flushTxReq,
  input logic [4:0]    flushTxSel,
  input logic          flushRxReq,
  input logic          rxFull,
  input logic [NF-1:0] fifoEmpty,
  input logic          pktRdValid,
  input logic          ovfErr,
  input logic          cfgErr
);
  // R5
  pkt_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktReq |-> !busGnt);

  // R5
  bus_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !pktReq) |-> busGnt);

  // R4
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && pktWr && rxFull && !cfgErr && !flushRxReq) |=> ovfErr);

  // R6
  pkt_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktRdValid |-> $past(pktReq && !pktWr));

  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushRxReq |=> fifoEmpty[0]);

  // R8
  tx_flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushTxReq && flushTxSel == 5'h10) |=> (&fifoEmpty[NF-1:1]));

  // R10
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && pktReq && pktWr) |=> !ovfErr);
endmodule

bind shared_fifo_mgr mfifo_chk #(.NUM_TX(NUM_TX)) chk_i (
  .clk(clk), .rstN(rstN), .pktReq(pktReq), .pktWr(pktWr), .busReq(busReq),
  .busGnt(busGnt), .flushTxReq(flushTxReq), .flushTxSel(flushTxSel),
  .flushRxReq(flushRxReq), .rxFull(fifoFull[0]), .fifoEmpty(fifoEmpty),
  .pktRdValid(pktRdValid), .ovfErr(ovfErr), .cfgErr(cfgErr)
);

// File: tb/shared_fifo_mgr_tb_top.sv
module shared_fifo_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_TX = 4;
  localparam int RAM_WORDS = 256;
  localparam int NF = NUM_TX + 1;
  localparam int DEPTH_W = $clog2(RAM_WORDS) + 1;
  localparam int TXSEL_W = $clog2(NUM_TX);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEPTH_W-1:0] cfgRxDepth;
  logic [NUM_TX*DEPTH_W-1:0] cfgTxDepth;
  logic flushTxReq, flushRxReq, pktReq, pktWr, busReq, busWr;
  logic [4:0] flushTxSel;
  logic [TXSEL_W-1:0] pktTxSel, busTxSel;
  logic [31:0] pktWrData, busWrData, rdData;
  logic busGnt, pktRdValid, busRdValid, ovfErr, udfErr, cfgErr;
  logic [NF-1:0] fifoFull, fifoEmpty;
  logic [NF*DEPTH_W-1:0] fifoLevel;

  int checks = 0;
  int errors = 0;
  int mdep [NF];
  int mcnt [NF];
  int mhead [NF];
  int mtotal;
  logic [31:0] mbuf [NF][RAM_WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_fifo_mgr #(.NUM_TX(NUM_TX), .RAM_WORDS(RAM_WORDS)) dut_i (
    .clk(clk), .rstN(rstN), .cfgRxDepth(cfgRxDepth), .cfgTxDepth(cfgTxDepth),
    .flushTxReq(flushTxReq), .flushTxSel(flushTxSel), .flushRxReq(flushRxReq),
    .pktReq(pktReq), .pktWr(pktWr), .pktTxSel(pktTxSel), .pktWrData(pktWrData),
    .busReq(busReq), .busWr(busWr), .busTxSel(busTxSel), .busWrData(busWrData),
    .busGnt(busGnt), .rdData(rdData), .pktRdValid(pktRdValid), .busRdValid(busRdValid),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel),
    .ovfErr(ovfErr), .udfErr(udfErr), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sumDepths();
    int s = 0;
    for (int i = 0; i < NF; i++) s += mdep[i];
    return s;
  endfunction

  task automatic applyCfg();
    cfgRxDepth = DEPTH_W'(mdep[0]);
    for (int k = 0; k < NUM_TX; k++) cfgTxDepth[k*DEPTH_W +: DEPTH_W] = DEPTH_W'(mdep[k+1]);
    mtotal = sumDepths();
  endtask

  // One cycle: drive at negedge, predict, then check registered outputs at next negedge.
  task automatic step(input bit pR, input bit pW, input int pS, input logic [31:0] pD,
                      input bit bR, input bit bW, input int bS, input logic [31:0] bD,
                      input bit fT, input int fS, input bit fR);
    bit fm [NF];
    bit hit, wr, bus, cerr, eOvf, eUdf, doW, doR;
    int tgt;
    logic [31:0] d, eData;
    string tag;
    pktReq = pR; pktWr = pW; pktTxSel = TXSEL_W'(pS); pktWrData = pD;
    busReq = bR; busWr = bW; busTxSel = TXSEL_W'(bS); busWrData = bD;
    flushTxReq = fT; flushTxSel = 5'(fS); flushRxReq = fR;
    #1;
    chk("R5 grant", 64'(busGnt), 64'(bR && !pR));
    for (int i = 0; i < NF; i++) fm[i] = 1'b0;
    if (fR) fm[0] = 1'b1;
    if (fT) begin
      if (fS == 16) for (int i = 1; i < NF; i++) fm[i] = 1'b1;
      else if (fS < NUM_TX) fm[fS+1] = 1'b1;
    end
    hit = 0; wr = 0; bus = 0; tgt = 0; d = '0;
    if (pR) begin hit = 1; wr = pW; tgt = pW ? 0 : pS + 1; d = pD; end
    else if (bR) begin hit = 1; bus = 1; wr = bW; tgt = bW ? bS + 1 : 0; d = bD; end
    if (hit && fm[tgt]) hit = 0;
    cerr = mtotal > RAM_WORDS;
    eOvf = hit && wr && mcnt[tgt] == mdep[tgt] && !cerr;
    eUdf = hit && !wr && mcnt[tgt] == 0;
    doW = hit && wr && mcnt[tgt] != mdep[tgt] && !cerr;
    doR = hit && !wr && mcnt[tgt] != 0;
    eData = doR ? mbuf[tgt][mhead[tgt]] : '0;
    @(posedge clk);
    for (int i = 0; i < NF; i++) if (fm[i]) begin mcnt[i] = 0; mhead[i] = 0; end
    if (doW) begin
      mbuf[tgt][(mhead[tgt] + mcnt[tgt]) % mdep[tgt]] = d;
      mcnt[tgt]++;
    end
    if (doR) begin
      mhead[tgt] = (mhead[tgt] + 1) % mdep[tgt];
      mcnt[tgt]--;
    end
    @(negedge clk);
    chk("R6 pkt valid", 64'(pktRdValid), 64'(doR && !bus));
    chk("R6 bus valid", 64'(busRdValid), 64'(doR && bus));
    if (doR) chk("R1,R2 data", 64'(rdData), 64'(eData));
    chk("R4 ovf", 64'(ovfErr), 64'(eOvf));
    chk("R4 udf", 64'(udfErr), 64'(eUdf));
    chk("R10 cfgErr", 64'(cfgErr), 64'(cerr));
    for (int i = 0; i < NF; i++) begin
      if (fm[i]) tag = (i == 0) ? "R9 level" : ((fS == 16) ? "R8 level" : "R7 level");
      else tag = cerr ? "R10 level" : "R3 level";
      chk(tag, 64'(fifoLevel[i*DEPTH_W +: DEPTH_W]), 64'(mcnt[i]));
      chk("R3 full", 64'(fifoFull[i]), 64'(mcnt[i] == mdep[i]));
      chk("R3 empty", 64'(fifoEmpty[i]), 64'(mcnt[i] == 0));
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic flushAll();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16, 1);
  endtask

  task automatic randomRun(input int n, input int wrPct);
    for (int s = 0; s < n; s++) begin
      step($urandom % 2, ($urandom % 100) < wrPct, $urandom % NUM_TX, $urandom,
           $urandom % 2, ($urandom % 100) < wrPct, $urandom % NUM_TX, $urandom,
           ($urandom % 64) == 0, (($urandom % 3) == 0) ? 16 : $urandom % NUM_TX,
           ($urandom % 80) == 0);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1F2E3D4C);
    pktReq = 0; pktWr = 0; pktTxSel = '0; pktWrData = '0;
    busReq = 0; busWr = 0; busTxSel = '0; busWrData = '0;
    flushTxReq = 0; flushTxSel = '0; flushRxReq = 0;
    mdep[0] = 4; mdep[1] = 3; mdep[2] = 5; mdep[3] = 2; mdep[4] = 6;
    for (int i = 0; i < NF; i++) begin mcnt[i] = 0; mhead[i] = 0; end
    applyCfg();
    repeat (3) @(negedge clk);
    // Reset state (R3, R4, R6)
    chk("R3 reset level", 64'(fifoLevel), 64'(0));
    chk("R3 reset empty", 64'(fifoEmpty), 64'({NF{1'b1}}));
    chk("R3 reset full", 64'(fifoFull), 64'(0));
    chk("R4 reset errs", 64'({ovfErr, udfErr}), 64'(0));
    chk("R6 reset valid", 64'({pktRdValid, busRdValid}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R5: both sides push in the same cycle, bus held then granted
    step(1, 1, 0, 32'hA0A0_0001, 1, 1, 1, 32'hB0B0_0001, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 1, 32'hB0B0_0001, 0, 0, 0);
    // R4: fill tx0 (depth 3) then overflow; drain then underflow
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 1, 0, 32'hC000_0000 + k, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R2: wrap through tx2 (depth 2)
    for (int r = 0; r < 4; r++) begin
      step(0, 0, 0, 0, 1, 1, 2, 32'hD000_0000 + 2*r, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 2, 32'hD000_0001 + 2*r, 0, 0, 0);
      step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    // R1: fill every FIFO completely, then drain all
    for (int k = 0; k < 6; k++) begin
      step(1, 1, 0, 32'hE000_0000 + k, 0, 0, 0, 0, 0, 0, 0);
      for (int t = 0; t < NUM_TX; t++) step(0, 0, 0, 0, 1, 1, t, 32'hE100_0000 + 256*t + k, 0, 0, 0);
    end
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      for (int t = 0; t < NUM_TX; t++) step(1, 0, t, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    // R7: single flush of tx2, then an unused selector
    for (int t = 0; t < NUM_TX; t++) step(0, 0, 0, 0, 1, 1, t, 32'hF000_0000 + t, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0);
    // R8: flush all transmit FIFOs, receive keeps its word
    step(1, 1, 0, 32'hF100_0000, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16, 0);
    // R9: receive flush with a same-cycle receive push (dropped, no error)
    step(1, 1, 0, 32'hF200_0000, 0, 0, 0, 0, 0, 0, 1);
    idle();

    // Random traffic over several layouts
    mdep[0] = 1 + $urandom % 40;
    for (int i = 1; i < NF; i++) mdep[i] = 1 + $urandom % 40;
    applyCfg(); flushAll();
    randomRun(1500, 55);
    for (int i = 0; i < NF; i++) mdep[i] = 1 + $urandom % 6;
    applyCfg(); flushAll();
    randomRun(1500, 60);
    for (int i = 0; i < NF; i++) mdep[i] = 30 + $urandom % 20;
    applyCfg(); flushAll();
    randomRun(1500, 70);

    // R10: oversized layout blocks pushes, pops still served
    for (int i = 0; i < NF; i++) mdep[i] = 100;
    applyCfg(); flushAll();
    step(1, 1, 0, 32'h1111_1111, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 3, 32'h2222_2222, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NF; i++) mdep[i] = 8;
    applyCfg(); flushAll();
    step(1, 1, 0, 32'h3333_3333, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule